// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block follows the row-buffer state of a single DRAM bank and expands each incoming read or write request into the DRAM command sequence that the request needs. A request carries a row and a column, plus a look-ahead flag from the request queue that says whether another queued request targets the same row. The block emits one command per cycle at most: row activation, column read, column write or precharge. Each command carries its row or column.

A configuration input selects how the bank is managed. With the open-row policy the row stays in the row buffer after an access, so a later access to the same row costs only a column command. With the closed-row policy the bank is precharged straight after the column command, unless the look-ahead flag says the row will be wanted again. Four down-counters enforce the minimum spacings between commands: activate to activate, activate to column, precharge to activate, and write to read. Each accepted request produces a one-cycle classification pulse (hit, bank closed, or conflict) for the scheduler that sits above the block.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset the bank is idle and precharged: `req_ready` is 1, `cmd_valid` is 0 and `outc_valid` is 0, and the first access is classified as bank closed.
- R2: An access to a closed bank (outcome code 2) issues ACTIVATE (code 0) with the request row on `cmd_row`, and then the column command on `cmd_col`: READ is code 1 and WRITE is code 2.
- R3: Under the open-row policy (`policy_closed`=0), an access to the open row (outcome code 1) issues only its column command.
- R4: An access to a row other than the open one (outcome code 3) issues PRECHARGE (code 3), then ACTIVATE of the new row, then the column command.
- R5: Under the closed-row policy (`policy_closed`=1), with `req_same_row`=0 the block issues PRECHARGE in the cycle after the column command, so the next access is classified as bank closed.
- R6: Under the closed-row policy, with `req_same_row`=1 no PRECHARGE follows the column command, and the next access to that row is a hit.
- R7: Two ACTIVATE commands are at least TRC cycles apart.
- R8: A READ comes at least TWTR cycles after the last WRITE.
- R9: A column command comes at least TRCD cycles after its ACTIVATE, and an ACTIVATE comes at least TRP cycles after a PRECHARGE.
- R10: `outc_valid` is high for exactly one cycle, the cycle after the request is accepted. Each command is issued in the first cycle that its spacings allow, and an ACTIVATE or PRECHARGE that opens a sequence falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_closed | input | 1 | 0 = open-row policy, 1 = closed-row policy |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_same_row | input | 1 | Another queued request targets the same row |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_code | output | 2 | 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE |
| cmd_row | output | ROW_W | Row carried by ACTIVATE |
| cmd_col | output | COL_W | Column carried by READ or WRITE |
| outc_valid | output | 1 | One-cycle request classification pulse |
| outc_code | output | 2 | 1 hit, 2 bank closed, 3 conflict |

## Verification
The classification pulse appears in the cycle after the accepting edge, and the bench samples it at the falling edge of that cycle. An ACTIVATE that opens a sequence is issued in that same cycle. A later command is due exactly one spacing after the command that gates it: TRCD after ACTIVATE, TRP after PRECHARGE, TWTR after a WRITE, or TRC after the previous ACTIVATE when that spacing dominates. The bench logs every command with its falling-edge cycle number and compares the differences against these exact values. A running monitor also checks every minimum spacing on every command that appears.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } bcmd_e;

  typedef enum logic [1:0] {
    OC_NONE     = 2'd0,
    OC_HIT      = 2'd1,
    OC_EMPTY    = 2'd2,
    OC_CONFLICT = 2'd3
  } boutc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_CLOSE
  } bstate_e;

  localparam int NTIMERS = 4;
  localparam int T_RC    = 0;
  localparam int T_RCD   = 1;
  localparam int T_RP    = 2;
  localparam int T_WTR   = 3;

endpackage

// File: rtl/bseq_gap_timer.sv
module bseq_gap_timer #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);
  localparam int CW = $clog2(GAP + 1) + 1;
  localparam logic [CW-1:0] LOADV = CW'((GAP > 0) ? GAP - 1 : 0);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (load) begin
      count_d = LOADV;
    end else if (count_q != '0) begin
      count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign ready = (count_q == '0);

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             policy_closed,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_same_row,
  input  logic             act_ok,
  input  logic             rd_ok,
  input  logic             wr_ok,
  output logic             cmd_valid,
  output bcmd_e            cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             outc_valid,
  output boutc_e           outc_code
);

  bstate_e          state_q, state_d;
  logic             open_q, open_d;
  logic [ROW_W-1:0] orow_q, orow_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic             same_q;
  logic             lat_en;
  logic             oc_v_d;
  boutc_e           oc_q, oc_d;
  logic             oc_en;

  always_comb begin
    state_d   = state_q;
    open_d    = open_q;
    orow_d    = orow_q;
    lat_en    = 1'b0;
    oc_v_d    = 1'b0;
    oc_d      = oc_q;
    oc_en     = 1'b0;
    cmd_valid = 1'b0;
    cmd_code  = CMD_ACT;
    cmd_row   = row_q;
    cmd_col   = col_q;
    req_ready = (state_q == ST_IDLE);

    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          lat_en = 1'b1;
          oc_v_d = 1'b1;
          oc_en  = 1'b1;
          if (!open_q) begin
            oc_d    = OC_EMPTY;
            state_d = ST_ACT;
          end else if (req_row == orow_q) begin
            oc_d    = OC_HIT;
            state_d = ST_COL;
          end else begin
            oc_d    = OC_CONFLICT;
            state_d = ST_PRE;
          end
        end
      end
      ST_PRE: begin
        cmd_valid = 1'b1;
        cmd_code  = CMD_PRE;
        open_d    = 1'b0;
        state_d   = ST_ACT;
      end
      ST_ACT: begin
        if (act_ok) begin
          cmd_valid = 1'b1;
          cmd_code  = CMD_ACT;
          open_d    = 1'b1;
          orow_d    = row_q;
          state_d   = ST_COL;
        end
      end
      ST_COL: begin
        if (wr_q ? wr_ok : rd_ok) begin
          cmd_valid = 1'b1;
          cmd_code  = wr_q ? CMD_WR : CMD_RD;
          state_d   = (policy_closed && !same_q) ? ST_CLOSE : ST_IDLE;
        end
      end
      ST_CLOSE: begin
        cmd_valid = 1'b1;
        cmd_code  = CMD_PRE;
        open_d    = 1'b0;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      open_q     <= 1'b0;
      orow_q     <= '0;
      outc_valid <= 1'b0;
    end else begin
      state_q    <= state_d;
      open_q     <= open_d;
      orow_q     <= orow_d;
      outc_valid <= oc_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
      same_q <= 1'b0;
    end else if (lat_en) begin
      row_q  <= req_row;
      col_q  <= req_col;
      wr_q   <= req_write;
      same_q <= req_same_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q <= OC_NONE;
    end else if (oc_en) begin
      oc_q <= oc_d;
    end
  end

  assign outc_code = oc_q;

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid); // R1

  AST_OUTC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    outc_valid |=> !outc_valid); // R10

  AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> outc_valid); // R10

  AST_HIT_NO_ROWCMD: assert property (@(posedge clk) disable iff (!rst_n)
    (outc_valid && outc_code == OC_HIT) |-> !(cmd_valid && cmd_code == CMD_ACT)); // R3

endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bseq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 11,
  parameter int TRC   = 8,
  parameter int TRCD  = 3,
  parameter int TRP   = 2,
  parameter int TWTR  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             policy_closed,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_same_row,
  output logic             cmd_valid,
  output logic [1:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             outc_valid,
  output logic [1:0]       outc_code
);

  localparam int GAPV [NTIMERS] = '{TRC, TRCD, TRP, TWTR};

  logic [NTIMERS-1:0] t_load;
  logic [NTIMERS-1:0] t_ready;
  bcmd_e              code_e;
  boutc_e             outc_e;
  logic               is_act, is_rd, is_wr, is_pre;

  for (genvar g = 0; g < NTIMERS; g++) begin : g_tmr
    bseq_gap_timer #(.GAP(GAPV[g])) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (t_load[g]),
      .ready (t_ready[g])
    );
  end

  bseq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .policy_closed (policy_closed),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_row       (req_row),
    .req_col       (req_col),
    .req_same_row  (req_same_row),
    .act_ok        (t_ready[T_RC] & t_ready[T_RP]),
    .rd_ok         (t_ready[T_RCD] & t_ready[T_WTR]),
    .wr_ok         (t_ready[T_RCD]),
    .cmd_valid     (cmd_valid),
    .cmd_code      (code_e),
    .cmd_row       (cmd_row),
    .cmd_col       (cmd_col),
    .outc_valid    (outc_valid),
    .outc_code     (outc_e)
  );

  assign cmd_code  = code_e;
  assign outc_code = outc_e;

  assign is_act = cmd_valid && (code_e == CMD_ACT);
  assign is_rd  = cmd_valid && (code_e == CMD_RD);
  assign is_wr  = cmd_valid && (code_e == CMD_WR);
  assign is_pre = cmd_valid && (code_e == CMD_PRE);

  always_comb begin
    t_load         = '0;
    t_load[T_RC]   = is_act;
    t_load[T_RCD]  = is_act;
    t_load[T_RP]   = is_pre;
    t_load[T_WTR]  = is_wr;
  end

  // Independent elapsed-cycle counters used only by the spacing assertions.
  localparam int MAXG = (TRC > TRCD ? TRC : TRCD) > (TRP > TWTR ? TRP : TWTR) ?
                        (TRC > TRCD ? TRC : TRCD) : (TRP > TWTR ? TRP : TWTR);
  localparam int SW = $clog2(MAXG + 2) + 1;
  localparam logic [SW-1:0] SAT = '1;

  logic [SW-1:0] since_act, since_pre, since_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= SAT;
      since_pre <= SAT;
      since_wr  <= SAT;
    end else begin
      since_act <= is_act ? SW'(1) : ((since_act == SAT) ? SAT : since_act + 1'b1);
      since_pre <= is_pre ? SW'(1) : ((since_pre == SAT) ? SAT : since_pre + 1'b1);
      since_wr  <= is_wr  ? SW'(1) : ((since_wr  == SAT) ? SAT : since_wr  + 1'b1);
    end
  end

  AST_ACT_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_act >= SW'(TRC)); // R7

  AST_WR_TO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> since_wr >= SW'(TWTR)); // R8

  AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> since_act >= SW'(TRCD)); // R9

  AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_pre >= SW'(TRP)); // R9

endmodule

// File: tb/bank_cmd_seq_test.sv
`timescale 1ns/1ps
module bank_cmd_seq_test;
  localparam int TRC  = 8;
  localparam int TRCD = 3;
  localparam int TRP  = 2;
  localparam int TWTR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        policy_closed = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [13:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic        req_same_row = 1'b0;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic [13:0] cmd_row;
  logic [10:0] cmd_col;
  logic        outc_valid;
  logic [1:0]  outc_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int cyc = 0;
  int lcount = 0;
  int log_code [0:255];
  int log_row  [0:255];
  int log_col  [0:255];
  int log_cyc  [0:255];
  int last_oc = 0;
  int last_oc_cyc = -1;
  int oc_count = 0;
  bit prev_oc = 1'b0;
  int last_act = -1;
  int last_pre = -1;
  int last_wr  = -1;

  always #4 clk = ~clk;

  bank_cmd_seq #(.TRC(TRC), .TRCD(TRCD), .TRP(TRP), .TWTR(TWTR)) uut (
    .clk(clk), .rst_n(rst_n), .policy_closed(policy_closed),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_same_row(req_same_row),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .outc_valid(outc_valid), .outc_code(outc_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // Command and outcome monitor, sampling at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (outc_valid) begin
        chk(!prev_oc, "R10 outcome pulse longer than one cycle", 1, 0);
        last_oc     = outc_code;
        last_oc_cyc = cyc;
        oc_count++;
      end
      prev_oc = outc_valid;
      if (cmd_valid) begin
        log_code[lcount] = cmd_code;
        log_row[lcount]  = cmd_row;
        log_col[lcount]  = cmd_col;
        log_cyc[lcount]  = cyc;
        lcount++;
        if (cmd_code == 2'd0) begin
          if (last_act >= 0) chk(cyc - last_act >= TRC, "R7 ACT-ACT gap", cyc - last_act, TRC);
          if (last_pre >= 0) chk(cyc - last_pre >= TRP, "R9 PRE-ACT gap", cyc - last_pre, TRP);
          last_act = cyc;
        end else if (cmd_code == 2'd3) begin
          last_pre = cyc;
        end else begin
          chk(last_act >= 0 && cyc - last_act >= TRCD, "R9 ACT-column gap", cyc - last_act, TRCD);
          if (cmd_code == 2'd1 && last_wr >= 0)
            chk(cyc - last_wr >= TWTR, "R8 WR-RD gap", cyc - last_wr, TWTR);
          if (cmd_code == 2'd2) last_wr = cyc;
        end
      end
    end
  end

  // Called at a falling edge; returns at the falling edge where the block is idle again.
  task automatic send(input bit wr, input int row, input int col, input bit same,
                      output int first);
    int oc_before;
    while (!req_ready) @(negedge clk);
    first        = lcount;
    oc_before    = oc_count;
    req_valid    = 1'b1;
    req_write    = wr;
    req_row      = 14'(row);
    req_col      = 11'(col);
    req_same_row = same;
    @(negedge clk);
    req_valid    = 1'b0;
    while (!req_ready) @(negedge clk);
    chk_eq("R10 one outcome per request", oc_count - oc_before, 1);
  endtask

  task automatic t_reset;
    chk_eq("R1 ready after reset", int'(req_ready), 1);
    chk_eq("R1 no command after reset", int'(cmd_valid), 0);
    chk_eq("R1 no outcome after reset", int'(outc_valid), 0);
  endtask

  task automatic t_closed_bank;
    int f;
    send(1'b0, 5, 7, 1'b0, f);
    chk_eq("R1 R2 first access outcome", last_oc, 2);
    chk_eq("R2 command count", lcount - f, 2);
    chk_eq("R2 ACT code", log_code[f], 0);
    chk_eq("R2 ACT row", log_row[f], 5);
    chk_eq("R2 READ code", log_code[f+1], 1);
    chk_eq("R2 READ col", log_col[f+1], 7);
    chk_eq("R10 ACT in outcome cycle", log_cyc[f], last_oc_cyc);
    chk_eq("R10 READ exactly TRCD after ACT", log_cyc[f+1] - log_cyc[f], TRCD);
  endtask

  task automatic t_open_hit_write;
    int f;
    send(1'b1, 5, 9, 1'b0, f);
    chk_eq("R3 hit outcome", last_oc, 1);
    chk_eq("R3 only column command", lcount - f, 1);
    chk_eq("R3 WRITE code", log_code[f], 2);
    chk_eq("R3 WRITE col", log_col[f], 9);
    chk_eq("R10 WRITE in outcome cycle", log_cyc[f], last_oc_cyc);
  endtask

  task automatic t_read_after_write;
    int f;
    send(1'b0, 5, 1, 1'b0, f);
    chk_eq("R3 hit outcome", last_oc, 1);
    chk_eq("R3 READ code", log_code[f], 1);
    chk_eq("R8 READ exactly TWTR after WRITE", log_cyc[f] - log_cyc[f-1], TWTR);
  endtask

  task automatic t_conflict;
    int f;
    send(1'b0, 9, 2, 1'b0, f);
    chk_eq("R4 conflict outcome", last_oc, 3);
    chk_eq("R4 command count", lcount - f, 3);
    chk_eq("R4 PRE first", log_code[f], 3);
    chk_eq("R4 ACT second", log_code[f+1], 0);
    chk_eq("R4 ACT row", log_row[f+1], 9);
    chk_eq("R4 READ col", log_col[f+2], 2);
    chk_eq("R10 PRE in outcome cycle", log_cyc[f], last_oc_cyc);
    chk_eq("R9 ACT exactly TRP after PRE", log_cyc[f+1] - log_cyc[f], TRP);
  endtask

  task automatic t_trc_bound;
    int f;
    send(1'b0, 12, 3, 1'b0, f);
    chk_eq("R4 conflict outcome", last_oc, 3);
    chk_eq("R7 ACT code", log_code[f+1], 0);
    chk_eq("R7 ACT exactly TRC after previous ACT", log_cyc[f+1] - log_cyc[f-2], TRC);
  endtask

  task automatic t_closed_policy;
    int f;
    policy_closed = 1'b1;
    send(1'b0, 20, 4, 1'b0, f);
    chk_eq("R5 command count", lcount - f, 4);
    chk_eq("R5 trailing PRE", log_code[f+3], 3);
    chk_eq("R5 PRE right after READ", log_cyc[f+3] - log_cyc[f+2], 1);
    send(1'b0, 20, 5, 1'b0, f);
    chk_eq("R5 next access sees closed bank", last_oc, 2);
    chk_eq("R5 ACT first", log_code[f], 0);
    chk_eq("R5 PRE closes again", log_code[f+2], 3);
  endtask

  task automatic t_lookahead;
    int f;
    send(1'b1, 30, 4, 1'b1, f);
    chk_eq("R6 closed-bank outcome", last_oc, 2);
    chk_eq("R6 no PRE with same-row flag", lcount - f, 2);
    chk_eq("R6 WRITE code", log_code[f+1], 2);
    send(1'b0, 30, 5, 1'b0, f);
    chk_eq("R6 next access is hit", last_oc, 1);
    chk_eq("R6 READ code", log_code[f], 1);
    chk_eq("R6 READ col", log_col[f], 5);
    chk_eq("R5 PRE after flagless access", log_code[f+1], 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_closed_bank();
    t_open_hit_write();
    t_read_after_write();
    t_conflict();
    t_trc_bound();
    t_closed_policy();
    t_lookahead();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule